// File: doc/BRIEF.md
# Link Pulse Page Burst Generator

This block turns one 16-bit negotiation page into a single burst of link pulses on a one-bit output. The burst is a train of 33 evenly spaced pulse slots. Slots alternate between clock slots and data slots, starting and ending with a clock slot. Every clock slot carries a pulse. A data slot carries a pulse only when its page bit is 1. The 16 data slots therefore carry the whole page, bit 0 first.

A page is handed over on a valid/ready input. The block accepts a page on a clock edge where both `page_valid_i` and `page_ready_o` are high, and it captures the page on that edge. `page_ready_o` stays low for the whole burst, so any request made during a burst waits; it is not taken. A producer may hold `page_valid_i` high with its data stable until it sees ready. `page_ready_o` rises again in the same cycle as the one-cycle `done_o` pulse, so a new page can be accepted immediately for a back-to-back burst.

The slot spacing and the pulse width are given in nanoseconds. They are converted to clock cycles from the clock-rate parameter, rounding up. With the defaults (50 MHz, 62.5 µs slots, 100 ns pulses) a slot is 3125 cycles long and a pulse is 5 cycles wide. The slot length must exceed the pulse width.

Top module: `flp_burst_gen`

## Requirements
- R1: While and after reset (`rst_ni` low, asynchronous), `pulse_o` and `done_o` are 0 and `page_ready_o` is 1.
- R2: A page is accepted on a rising edge where `page_valid_i` and `page_ready_o` are both 1. `page_ready_o` is 0 from the next cycle until the cycle in which `done_o` is 1. Requests made while `page_ready_o` is 0 neither restart nor alter the burst.
- R3: An accepted page produces exactly 33 pulse slots. The first pulse starts in the cycle after acceptance. The number of pulses is 17 plus the number of 1 bits in the page.
- R4: Every pulse starts on a slot boundary. Slot k (k = 0..32) begins SLOT_CYC·k + 1 cycles after the accepting edge, where SLOT_CYC = ceil(CLK_MHZ·SLOT_NS/1000).
- R5: Slots with an even index k (the 1st, 3rd, … 33rd slots) always carry a pulse.
- R6: Slot k = 2j+1 carries a pulse exactly when page bit j is 1 (j = 0..15). Bit 0 goes out first.
- R7: Each pulse is high for exactly PULSE_CYC = ceil(CLK_MHZ·PULSE_NS/1000) cycles at the start of its slot. `pulse_o` is 0 at all other times, including when idle.
- R8: `done_o` is high for exactly one cycle, 33·SLOT_CYC + 1 cycles after the accepting edge, that is, in the cycle right after the last slot ends.
- R9: In the `done_o` cycle `page_ready_o` is 1. A page offered then is accepted, and its burst follows with no gap.
- R10: The page is sampled only at acceptance. Changing `page_i` during a burst does not change the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_i | input | 16 | Page to send, bit 0 first |
| page_valid_i | input | 1 | Page offered |
| page_ready_o | output | 1 | Block idle and able to take a page |
| pulse_o | output | 1 | Link pulse output |
| done_o | output | 1 | One-cycle end-of-burst flag |

## Verification
The bench sends a set of pages that each expose a different fault:
- An all-zero page leaves only the 17 clock pulses, which shows that clock slots do not depend on the data.
- An all-one page fills all 33 slots.
- Pages with a single bit set at position 0 or at position 15 expose a reversed or shifted bit order.
- Mixed patterns check per-bit decoding. For each page, the bench counts pulses, checks that every pulse starts on the slot grid with the right width, and decodes the page back.

During each burst the bench also drives a different page with valid high, to show that a busy block ignores it. Directed cases cover reset in the middle of a burst and a back-to-back burst accepted in the `done_o` cycle.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int NUM_SLOTS = 33;
  localparam int PAGE_W    = 16;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);

  // Cycles covering a span of ns at a given clock rate, rounded up.
  function automatic int ns_to_cyc(input int clk_mhz, input int span_ns);
    return (clk_mhz * span_ns + 999) / 1000;
  endfunction
endpackage

// File: rtl/flp_slot_timer.sv
module flp_slot_timer #(
  parameter int SLOT_CYC  = 3125,
  parameter int PULSE_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic slot_end_o,
  output logic in_pulse_o
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] PW_CNT   = CW'(PULSE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      if (cnt_q == LAST_CNT) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign slot_end_o = run_i && (cnt_q == LAST_CNT);
  assign in_pulse_o = run_i && (cnt_q < PW_CNT);
endmodule

// File: rtl/flp_slot_seq.sv
module flp_slot_seq
  import flp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic slot_end_i,
  output logic busy_o,
  output logic data_slot_o,
  output logic data_adv_o,
  output logic done_o
);
  logic [SLOT_IDX_W-1:0] slot_q;
  logic                  busy_q;
  logic                  done_q;
  logic                  last_slot;

  assign last_slot = (slot_q == SLOT_IDX_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        slot_q <= '0;
        busy_q <= 1'b1;
      end else if (slot_end_i) begin
        if (last_slot) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign data_slot_o = slot_q[0];
  assign data_adv_o  = slot_end_i && slot_q[0];
  assign done_o      = done_q;
endmodule

// File: rtl/flp_page_shift.sv
module flp_page_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] page_i,
  input  logic             shift_i,
  output logic             bit_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= page_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[WIDTH-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen
  import flp_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int SLOT_NS  = 62500,
  parameter int PULSE_NS = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              page_valid_i,
  output logic              page_ready_o,
  output logic              pulse_o,
  output logic              done_o
);
  localparam int SLOT_CYC  = ns_to_cyc(CLK_MHZ, SLOT_NS);
  localparam int PULSE_CYC = ns_to_cyc(CLK_MHZ, PULSE_NS);

  logic busy, accept, slot_end, in_pulse, data_slot, data_adv, cur_bit;

  assign page_ready_o = !busy;
  assign accept       = page_valid_i && !busy;

  flp_slot_timer #(.SLOT_CYC(SLOT_CYC), .PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .run_i      (busy),
    .slot_end_o (slot_end),
    .in_pulse_o (in_pulse)
  );

  flp_slot_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept),
    .slot_end_i  (slot_end),
    .busy_o      (busy),
    .data_slot_o (data_slot),
    .data_adv_o  (data_adv),
    .done_o      (done_o)
  );

  flp_page_shift #(.WIDTH(PAGE_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .page_i  (page_i),
    .shift_i (data_adv),
    .bit_o   (cur_bit)
  );

  // Clock slots always pulse; data slots pulse on a one-bit.
  assign pulse_o = in_pulse && (!data_slot || cur_bit);
endmodule

// File: rtl/flp_burst_gen_chk.sv
module flp_burst_gen_chk
  import flp_pkg::*;
#(
  parameter int CLK_MHZ  = 50,
  parameter int SLOT_NS  = 62500,
  parameter int PULSE_NS = 100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic page_valid_i,
  input logic page_ready_o,
  input logic pulse_o,
  input logic done_o
);
  localparam int PULSE_CYC = ns_to_cyc(CLK_MHZ, PULSE_NS);

  logic [15:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_run_q <= '0;
    else if (pulse_o) hi_run_q <= hi_run_q + 1'b1;
    else              hi_run_q <= '0;
  end

  assert_accept_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_valid_i && page_ready_o) |=> (!page_ready_o && pulse_o));

  assert_busy_from_request_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(page_ready_o) |-> $past(page_valid_i));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_ready_o |-> !pulse_o);

  assert_pulse_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> (hi_run_q == 16'(PULSE_CYC)));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> page_ready_o);
endmodule

bind flp_burst_gen flp_burst_gen_chk #(
  .CLK_MHZ(CLK_MHZ), .SLOT_NS(SLOT_NS), .PULSE_NS(PULSE_NS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .page_valid_i (page_valid_i),
  .page_ready_o (page_ready_o),
  .pulse_o      (pulse_o),
  .done_o       (done_o)
);

// File: tb/test_flp_burst_gen.sv
module test_flp_burst_gen;
  localparam int CLK_MHZ  = 50;
  localparam int SLOT_NS  = 1000;
  localparam int PULSE_NS = 100;
  // From R4/R7: 1000 ns and 100 ns at 50 MHz
  localparam int SLOT = 50;
  localparam int PW   = 5;
  localparam int LAST = 33 * SLOT + 1;

  localparam logic [15:0] PAGES [8] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000,
                                        16'hA5C3, 16'h5A3C, 16'h1234, 16'hBEEF};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] page = '0;
  logic        ready, pulse, done;
  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flp_burst_gen #(.CLK_MHZ(CLK_MHZ), .SLOT_NS(SLOT_NS), .PULSE_NS(PULSE_NS)) i_flp_burst_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .page_i       (page),
    .page_valid_i (valid),
    .page_ready_o (ready),
    .pulse_o      (pulse),
    .done_o       (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [15:0] pg, input bit armed,
                           input bit chain, input logic [15:0] nxt);
    int rises = 0, bad_grid = 0, bad_w = 0, bad_clk = 0, bad_done = 0, bad_rdy = 0, run = 0;
    logic prev = 1'b0;
    logic [15:0] got = '0;
    if (!armed) begin
      @(negedge clk);
      check(ready === 1'b1, "R2", "ready before start", int'(ready), 1);
      valid = 1'b1;
      page  = pg;
    end
    @(posedge clk);
    for (int t = 1; t <= LAST; t++) begin
      int s;
      int off;
      @(negedge clk);
      s   = (t - 1) / SLOT;
      off = (t - 1) % SLOT;
      if (t == 1) begin valid = 1'b1; page = ~pg; end   // request while busy (R2, R10)
      if (t == 4) valid = 1'b0;
      if (pulse && !prev) begin
        rises++;
        if (off != 0) bad_grid++;
      end
      if (!pulse && prev && run != PW) bad_w++;
      run = pulse ? run + 1 : 0;
      if (off == 0 && t < LAST) begin
        if (s % 2 == 0) begin
          if (!pulse) bad_clk++;
        end else begin
          got[(s - 1) / 2] = pulse;
        end
      end
      if (t == LAST && pulse) bad_w++;
      if (done !== (t == LAST)) bad_done++;
      if (ready !== (t == LAST)) bad_rdy++;
      prev = pulse;
      if (t == LAST && chain) begin valid = 1'b1; page = nxt; end
    end
    check(rises == 17 + $countones(pg), "R3", "pulse count", rises, 17 + $countones(pg));
    check(bad_grid == 0, "R4", "pulses off slot grid", bad_grid, 0);
    check(bad_clk == 0, "R5", "missing clock pulses", bad_clk, 0);
    check(got == pg, "R6/R10", "decoded page", int'(got), int'(pg));
    check(bad_w == 0, "R7", "bad pulse widths", bad_w, 0);
    check(bad_done == 0, "R8", "done timing errors", bad_done, 0);
    check(bad_rdy == 0, "R2", "ready timing errors", bad_rdy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int hi = 0;
    repeat (3) @(negedge clk);
    check(pulse === 1'b0 && done === 1'b0 && ready === 1'b1, "R1", "outputs in reset",
          int'({pulse, done, ready}), 1);
    rst_n = 1'b1;
    // R7: idle with no request stays quiet
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pulse) hi++;
    end
    check(hi == 0, "R7", "idle pulses", hi, 0);

    // Table of pages
    for (int v = 0; v < 8; v++) run_burst(PAGES[v], 1'b0, 1'b0, 16'h0);

    // R9: back-to-back bursts, second accepted in the done cycle
    run_burst(16'hC0DE, 1'b0, 1'b1, 16'h0F0F);
    run_burst(16'h0F0F, 1'b1, 1'b0, 16'h0);
    @(negedge clk);
    check(done === 1'b0, "R8", "done after one cycle", int'(done), 0);

    // R1: reset in the middle of a burst
    @(negedge clk);
    valid = 1'b1;
    page  = 16'hFFFF;
    @(negedge clk);
    valid = 1'b0;
    repeat (SLOT + 1) @(negedge clk);   // inside a pulse of slot 1
    rst_n = 1'b0;
    #1;
    check(pulse === 1'b0 && done === 1'b0 && ready === 1'b1, "R1", "outputs after mid-burst reset",
          int'({pulse, done, ready}), 1);
    @(negedge clk);
    rst_n = 1'b1;
    run_burst(16'h6001, 1'b0, 1'b0, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule